// File: doc/BRIEF.md
# Neighbourhood Block-Sort Exchange Sequencer

This block is the control unit for one sorter module inside a linear chain of identical modules. Together the modules sort a large vector set by alternating between a local sort and a swap of half the module's content with one neighbour. The sequencer counts cycles through a fixed round of four phases. From that count it drives the source select of the input data multiplexer, the fill enable of the input shift array, the drain enable of the output shift array, the sorter start pulse and the rank direction. It also drives the valid strobes towards both neighbours, the check window, and a chained ordering flag for the global completion test.

Every phase is `SLOTS + BITS` cycles long, so a round lasts `4 * (SLOTS + BITS)` cycles. Phases 0 and 2 are exchange phases. In phase 0, data arrives from the left neighbour during the first half of the slots and own data fills the rest. Phase 2 is the mirror image: own data comes first and the right neighbour's data follows. In both exchange phases the last `BITS` cycles are a check window. Phases 1 and 3 keep the registers idle and only shift data inside the core. A module at the left end of the chain is fed all-zero vectors in place of neighbour data, and a module at the right end is fed all-one vectors. As a result, every module runs the same sequence wherever it sits in the chain.

Top module: `nbs_exchange_seq`

## Requirements
- R1: While reset is low and after reset until the first start, `busy` and every enable and strobe output are 0, `src_sel` is 00 and `all_sorted` is 0.
- R2: After a start, the phase advances every `SLOTS+BITS` cycles through phases 0,1,2,3 and the round repeats without a gap; cycle t after start lies in phase (t/(SLOTS+BITS)) mod 4 at in-phase index t mod (SLOTS+BITS).
- R3: In phase 0, with HALF = ceil(SLOTS/2): `src_sel` is 01 (left) for index < HALF and 00 (own) otherwise; `rank_max` and `tx_right_vld` are high for index < HALF.
- R4: In phase 2: `src_sel` is 00 for index < HALF, 10 (right) for HALF <= index < SLOTS, and 00 in the check window; `rank_max` is high for index < HALF; `tx_left_vld` is high for HALF <= index < SLOTS.
- R5: In phases 1 and 3, `core_shift` is high, every other enable and strobe is low, and `src_sel` is 00.
- R6: In phases 0 and 2, `out_shift_en` is high for the whole phase, `sort_start` pulses at index 0, `chk_win` is high for index >= SLOTS, and the fill enable is only possible for index < SLOTS.
- R7: When `src_sel` is 01 on a left-edge module, `src_data` is all zeros; when it is 10 on a right-edge module, `src_data` is all ones; otherwise the selected neighbour's data passes through.
- R8: `in_shift_en` is high for index < SLOTS of an exchange phase only if the selected source is own data, is an edge sentinel, or is the neighbour whose valid input (`rx_left_vld` / `rx_right_vld`) is high in that cycle.
- R9: `src_sel` never carries 11; the multiplexer returns `own_data` for 00 and for any code other than 01 and 10.
- R10: A start pulse at any time restarts the count at phase 0, index 0 on the next cycle and clears `all_sorted`.
- R11: A stop pulse lets the current round finish and clears `busy` right after the last cycle of phase 3; the sequencer then stays idle until the next start.
- R12: `chain_ok_out` equals `chain_ok_in AND local_ok`; `all_sorted` takes that value at the last cycle of each check window and holds it otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Restart the round from phase 0 |
| stop | input | 1 | Halt at the next round boundary |
| left_edge | input | 1 | Strap: module has no left neighbour |
| right_edge | input | 1 | Strap: module has no right neighbour |
| rx_left_vld | input | 1 | Left neighbour's data is valid for this module |
| rx_right_vld | input | 1 | Right neighbour's data is valid for this module |
| own_data | input | BITS | Module's own sorted output vector |
| left_data | input | BITS | Vector from the left neighbour |
| right_data | input | BITS | Vector from the right neighbour |
| local_ok | input | 1 | Local ordering condition against the right neighbour |
| chain_ok_in | input | 1 | Ordering flag from the right part of the chain |
| busy | output | 1 | Sequencer running |
| src_sel | output | 2 | Source select: 00 own, 01 left, 10 right |
| src_data | output | BITS | Selected vector to the input shift array |
| in_shift_en | output | 1 | Input shift array fill enable |
| out_shift_en | output | 1 | Output shift array drain enable |
| sort_start | output | 1 | One-cycle sorter start |
| rank_max | output | 1 | Sorter produces the maximum half (high) or the minimum half (low) |
| core_shift | output | 1 | Shift data inside the core (idle-register phase) |
| chk_win | output | 1 | Global check window |
| tx_left_vld | output | 1 | Strobe: minimum half going to the left neighbour |
| tx_right_vld | output | 1 | Strobe: maximum half going to the right neighbour |
| chain_ok_out | output | 1 | Ordering flag passed to the left |
| all_sorted | output | 1 | Registered ordering result of the last check window |

## Verification
The bench sweeps every cycle of whole rounds in a small configuration (5 slots of 3 bits). It compares each output against the phase table computed arithmetically, so a window that is one cycle long or short at HALF, at SLOTS or at a phase wrap shows up at once. Separate sweeps tie the edge straps high with the neighbour valids low, and toggle the valids on a non-edge module. The first catches a sentinel with the wrong polarity, and the second catches data accepted without the right neighbour's strobe. A stop raised mid-round and one raised in the very last cycle of the round both have to end exactly at the round boundary; a design that halts early or runs an extra round fails there. A start issued mid-run must rewind to index 0 and drop a set `all_sorted` flag.

// File: rtl/nbs_pkg.sv
// Shared source-select codes and the decoded control bundle for the
// neighbourhood exchange sequencer. Assumes a 2-bit select bus.
package nbs_pkg;
    localparam logic [1:0] SEL_OWN   = 2'b00;
    localparam logic [1:0] SEL_LEFT  = 2'b01;
    localparam logic [1:0] SEL_RIGHT = 2'b10;

    typedef struct packed {
        logic in_en_raw;   // fill window before neighbour acceptance
        logic out_en;
        logic sort_start;
        logic rank_max;
        logic core_shift;
        logic chk_win;
        logic chk_last;    // last cycle of a check window
        logic tx_left;
        logic tx_right;
    } ctl_t;
endpackage

// File: rtl/nbs_round_ctr.sv
// Phase and in-phase cycle counter. Counts PLEN = SLOTS+BITS cycles per
// phase, four phases per round. Start restarts from zero at any time; a
// stop request is held until the end of phase 3, where counting halts.
// Assumes start and stop are synchronous single-cycle or level inputs.
module nbs_round_ctr #(
    parameter int SLOTS = 127,
    parameter int BITS  = 16,
    localparam int PLEN = SLOTS + BITS,
    localparam int CW   = $clog2(PLEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          stop,
    output logic          run,
    output logic [1:0]    phase,
    output logic [CW-1:0] cyc
);
    logic stop_pend;
    logic last_cyc;

    assign last_cyc = (cyc == CW'(PLEN - 1));

    // Advance the cycle and phase count, honour start and stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run       <= 1'b0;
            phase     <= 2'd0;
            cyc       <= '0;
            stop_pend <= 1'b0;
        end else if (start) begin
            run       <= 1'b1;
            phase     <= 2'd0;
            cyc       <= '0;
            stop_pend <= 1'b0;
        end else if (run) begin
            if (stop) stop_pend <= 1'b1;
            if (last_cyc) begin
                cyc   <= '0;
                phase <= phase + 2'd1;
                if (phase == 2'd3 && (stop_pend || stop)) begin
                    run       <= 1'b0;
                    stop_pend <= 1'b0;
                end
            end else begin
                cyc <= cyc + 1'b1;
            end
        end
    end

    // R2: the in-phase index wraps to zero and the phase steps by one
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !start && last_cyc) |=> (cyc == '0 && phase == $past(phase) + 2'd1));

    // R11: running stops only right after the last cycle of phase 3
    p_halt_boundary_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run) |-> ($past(phase) == 2'd3 && $past(cyc) == CW'(PLEN - 1)));

    // R11: once halted, only a start wakes the counter
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !start) |=> !run);
endmodule

// File: rtl/nbs_phase_decode.sv
// Decodes phase and in-phase index into the select code and the control
// bundle. Exchange phases are 0 (left first) and 2 (right second);
// phases 1 and 3 only shift inside the core. Everything is low when the
// counter is not running. clk and rst_n are used by the checks only.
module nbs_phase_decode
    import nbs_pkg::*;
#(
    parameter int SLOTS = 127,
    parameter int BITS  = 16,
    localparam int PLEN = SLOTS + BITS,
    localparam int CW   = $clog2(PLEN),
    localparam int HALF = (SLOTS + 1) / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [1:0]    phase,
    input  logic [CW-1:0] cyc,
    output logic [1:0]    sel,
    output ctl_t          ctl
);
    logic xchg, first_half, slot_win;

    assign xchg       = run && (phase == 2'd0 || phase == 2'd2);
    assign first_half = (cyc < CW'(HALF));
    assign slot_win   = (cyc < CW'(SLOTS));

    // Map the current position in the round onto select and enables.
    always_comb begin
        ctl = '0;
        sel = SEL_OWN;
        if (run) begin
            ctl.core_shift = !xchg;
            if (xchg) begin
                ctl.in_en_raw  = slot_win;
                ctl.out_en     = 1'b1;
                ctl.sort_start = (cyc == '0);
                ctl.rank_max   = first_half;
                ctl.chk_win    = !slot_win;
                ctl.chk_last   = (cyc == CW'(PLEN - 1));
                if (phase == 2'd0) begin
                    ctl.tx_right = first_half;
                    if (first_half) sel = SEL_LEFT;
                end else begin
                    ctl.tx_left = !first_half && slot_win;
                    if (!first_half && slot_win) sel = SEL_RIGHT;
                end
            end
        end
    end

    // R9: the illegal select code is never produced
    p_sel_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sel != 2'b11);

    // R3: the two neighbour strobes are never active together
    p_tx_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl.tx_left && ctl.tx_right));

    // R5: idle-register phases leave the shift arrays alone
    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.core_shift |-> !(ctl.in_en_raw || ctl.out_en || ctl.sort_start));
endmodule

// File: rtl/nbs_src_mux.sv
// Input data multiplexer with edge sentinels. A left-edge module sees
// all-zero vectors and a right-edge module all-one vectors instead of
// neighbour data. Any code other than left or right yields own data.
module nbs_src_mux
    import nbs_pkg::*;
#(
    parameter int BITS = 16
) (
    input  logic [1:0]      sel,
    input  logic            left_edge,
    input  logic            right_edge,
    input  logic [BITS-1:0] own_data,
    input  logic [BITS-1:0] left_data,
    input  logic [BITS-1:0] right_data,
    output logic [BITS-1:0] data_out
);
    // Pick the source vector, substituting sentinels at chain ends.
    always_comb begin
        case (sel)
            SEL_LEFT:  data_out = left_edge  ? '0 : left_data;
            SEL_RIGHT: data_out = right_edge ? '1 : right_data;
            default:   data_out = own_data;
        endcase
    end
endmodule

// File: rtl/nbs_exchange_seq.sv
// Top of the exchange sequencer for one sorter module of the chain.
// Combines the round counter, the phase decoder and the source mux,
// gates the fill enable with the neighbour valid strobes and keeps the
// registered global ordering flag. Assumes all modules share one clock
// and start together, so neighbour strobes line up cycle for cycle.
module nbs_exchange_seq
    import nbs_pkg::*;
#(
    parameter int SLOTS = 127,
    parameter int BITS  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            stop,
    input  logic            left_edge,
    input  logic            right_edge,
    input  logic            rx_left_vld,
    input  logic            rx_right_vld,
    input  logic [BITS-1:0] own_data,
    input  logic [BITS-1:0] left_data,
    input  logic [BITS-1:0] right_data,
    input  logic            local_ok,
    input  logic            chain_ok_in,
    output logic            busy,
    output logic [1:0]      src_sel,
    output logic [BITS-1:0] src_data,
    output logic            in_shift_en,
    output logic            out_shift_en,
    output logic            sort_start,
    output logic            rank_max,
    output logic            core_shift,
    output logic            chk_win,
    output logic            tx_left_vld,
    output logic            tx_right_vld,
    output logic            chain_ok_out,
    output logic            all_sorted
);
    localparam int PLEN = SLOTS + BITS;
    localparam int CW   = $clog2(PLEN);

    logic          run;
    logic [1:0]    phase;
    logic [CW-1:0] cyc;
    ctl_t          ctl;
    logic          accept;

    nbs_round_ctr #(.SLOTS(SLOTS), .BITS(BITS)) ctr_i (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
        .run(run), .phase(phase), .cyc(cyc)
    );

    nbs_phase_decode #(.SLOTS(SLOTS), .BITS(BITS)) dec_i (
        .clk(clk), .rst_n(rst_n), .run(run), .phase(phase), .cyc(cyc),
        .sel(src_sel), .ctl(ctl)
    );

    nbs_src_mux #(.BITS(BITS)) mux_i (
        .sel(src_sel), .left_edge(left_edge), .right_edge(right_edge),
        .own_data(own_data), .left_data(left_data), .right_data(right_data),
        .data_out(src_data)
    );

    // Accept neighbour data only from the neighbour that is strobing it.
    always_comb begin
        case (src_sel)
            SEL_LEFT:  accept = left_edge  || rx_left_vld;
            SEL_RIGHT: accept = right_edge || rx_right_vld;
            default:   accept = 1'b1;
        endcase
    end

    assign busy         = run;
    assign in_shift_en  = ctl.in_en_raw && accept;
    assign out_shift_en = ctl.out_en;
    assign sort_start   = ctl.sort_start;
    assign rank_max     = ctl.rank_max;
    assign core_shift   = ctl.core_shift;
    assign chk_win      = ctl.chk_win;
    assign tx_left_vld  = ctl.tx_left;
    assign tx_right_vld = ctl.tx_right;
    assign chain_ok_out = chain_ok_in && local_ok;

    // Capture the chained ordering result at the end of each check window.
    always_ff @(posedge clk) begin
        if (!rst_n || start) all_sorted <= 1'b0;
        else if (ctl.chk_last) all_sorted <= chain_ok_in && local_ok;
    end

    // R8: left neighbour data enters only under its strobe or as sentinel
    p_accept_left_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_shift_en && src_sel == SEL_LEFT) |-> (left_edge || rx_left_vld));

    // R7: a left-edge module never passes anything but the zero sentinel
    p_sentinel_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == SEL_LEFT && left_edge) |-> (src_data == '0));

    // R12: the ordering flag changes only after a check window closes
    p_sorted_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.chk_last && !start) |=> $stable(all_sorted));

    // R6: the fill enable never reaches into the check window
    p_fill_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_shift_en |-> !chk_win);
endmodule

// File: tb/nbs_exchange_seq_tb_top.sv
`timescale 1ns/1ps
module nbs_exchange_seq_tb_top;
    localparam int SL   = 5;
    localparam int BT   = 3;
    localparam int P    = SL + BT;
    localparam int H    = (SL + 1) / 2;
    localparam int RND  = 4 * P;

    logic clk = 1'b0;
    logic rst_n, start, stop, left_edge, right_edge, rx_left_vld, rx_right_vld;
    logic [BT-1:0] own_data, left_data, right_data;
    logic local_ok, chain_ok_in;
    logic busy, in_shift_en, out_shift_en, sort_start, rank_max, core_shift;
    logic chk_win, tx_left_vld, tx_right_vld, chain_ok_out, all_sorted;
    logic [1:0] src_sel;
    logic [BT-1:0] src_data;

    int total = 0;
    int bad = 0;
    bit exp_sorted = 1'b0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    nbs_exchange_seq #(.SLOTS(SL), .BITS(BT)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
        .left_edge(left_edge), .right_edge(right_edge),
        .rx_left_vld(rx_left_vld), .rx_right_vld(rx_right_vld),
        .own_data(own_data), .left_data(left_data), .right_data(right_data),
        .local_ok(local_ok), .chain_ok_in(chain_ok_in),
        .busy(busy), .src_sel(src_sel), .src_data(src_data),
        .in_shift_en(in_shift_en), .out_shift_en(out_shift_en),
        .sort_start(sort_start), .rank_max(rank_max), .core_shift(core_shift),
        .chk_win(chk_win), .tx_left_vld(tx_left_vld), .tx_right_vld(tx_right_vld),
        .chain_ok_out(chain_ok_out), .all_sorted(all_sorted)
    );

    task automatic chk(input string what, input int t, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s t=%0d actual=%0h expected=%0h", tag, what, t, act, exp);
        end
    endtask

    // Expected outputs from the phase table at cycle t after start.
    task automatic step_check(input int t, input bit run_exp);
        int ph = (t / P) % 4;
        int c = t % P;
        bit x = run_exp && (ph == 0 || ph == 2);
        logic [1:0] esel = 2'b00;
        logic [BT-1:0] edata;
        bit acc, e_in;
        if (run_exp && ph == 0 && c < H) esel = 2'b01;
        if (run_exp && ph == 2 && c >= H && c < SL) esel = 2'b10;
        case (esel)
            2'b01:   edata = left_edge ? '0 : left_data;
            2'b10:   edata = right_edge ? '1 : right_data;
            default: edata = own_data;
        endcase
        acc = (esel == 2'b00) || (esel == 2'b01 && (left_edge || rx_left_vld))
              || (esel == 2'b10 && (right_edge || rx_right_vld));
        e_in = x && c < SL && acc;
        #1;
        chk("R3/R4/R9 sel", t, 16'(src_sel), 16'(esel));
        chk("R7/R9 data", t, 16'(src_data), 16'(edata));
        chk("R2/R5/R6/R8 ctl", t,
            16'({busy, in_shift_en, out_shift_en, sort_start, rank_max, core_shift, chk_win}),
            16'({run_exp, e_in, x, x && c == 0, x && c < H, run_exp && !x, x && c >= SL}));
        chk("R3/R4 strobe", t, 16'({tx_left_vld, tx_right_vld}),
            16'({run_exp && ph == 2 && c >= H && c < SL, run_exp && ph == 0 && c < H}));
        chk("R12 sorted", t, 16'(all_sorted), 16'(exp_sorted));
        chk("R12 chain", t, 16'(chain_ok_out), 16'(chain_ok_in && local_ok));
        if (x && c == P - 1) exp_sorted = chain_ok_in && local_ok;
    endtask

    // Drive inputs for cycle t; mode picks edges, valids and flags.
    task automatic drive(input int t, input int mode);
        own_data   = BT'(t);
        left_data  = BT'(t * 5 + 1);
        right_data = BT'(t + 3);
        left_edge  = (mode == 1);
        right_edge = (mode == 1);
        rx_left_vld  = (mode == 2) ? t[0] : (mode != 1);
        rx_right_vld = (mode == 2) ? t[1] : (mode != 1);
        chain_ok_in = (mode == 3) ? 1'b1 : (t % 16 != 7);
        local_ok    = (mode == 3) ? 1'b1 : (t % 64 != 55);
    endtask

    task automatic do_start;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        exp_sorted = 1'b0;
    endtask

    task automatic run_span(input int n, input int mode);
        for (int t = 0; t < n; t++) begin
            drive(t, mode);
            step_check(t, 1'b1);
            @(negedge clk);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; stop = 1'b0;
        drive(0, 0);
        repeat (3) @(negedge clk);
        tag = "R1";
        step_check(0, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            step_check(0, 1'b0);
            @(negedge clk);
        end

        tag = "R2";            // two full rounds, all neighbours valid
        do_start;
        run_span(2 * RND, 0);

        tag = "R7";            // both edges strapped, neighbours silent
        do_start;
        run_span(RND, 1);

        tag = "R8";            // toggling neighbour valid strobes
        do_start;
        run_span(RND, 2);

        tag = "R10";           // restart mid-run after the flag has set
        do_start;
        run_span(20, 3);
        do_start;
        run_span(P + 2, 3);

        tag = "R11";           // stop raised mid-round
        do_start;
        for (int t = 0; t < RND + 4; t++) begin
            drive(t, 0);
            stop = (t == 10);
            step_check(t, t < RND);
            @(negedge clk);
        end
        stop = 1'b0;

        tag = "R11 last";      // stop raised in the final round cycle
        do_start;
        for (int t = 0; t < RND + 3; t++) begin
            drive(t, 0);
            stop = (t == RND - 1);
            step_check(t, t < RND);
            @(negedge clk);
        end
        stop = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule